// File: doc/BRIEF.md
# Bridge Configuration Control Register File

This block holds the bridge-only part of a type-1 configuration header: the three bus numbers, the secondary latency timer, the secondary status flags, the I/O, memory and prefetchable base/limit fields together with their upper halves, and the bridge control word. It also serves the fixed identity dwords (identity, class code with revision, header type). A configuration engine that sits outside this block decodes each transaction and delivers a single-cycle write strobe with a dword index, four byte enables and 32 bits of data. It reads any dword through a combinational read port. The block does not decode windows.

A per-bit write mask protects every field, so bits that are not writable ignore written data. A one-cycle `fwd_off` strobe parks all three windows in the closed state: each base is above its limit. A build-time parameter can make this closed state the reset value as well. The bus-reset bit of bridge control is watched for rising transitions, and each rising transition produces one pulse on `sec_bus_rst`. Every control and strap pin is a plain level or strobe. There is no back-pressure: a write strobe always completes in the cycle it is presented.

Top module: `pcib_cfg_regs`

## Requirements
- R1: After reset, dword 6 (primary bus [7:0], secondary bus [15:8], subordinate bus [23:16], latency timer [31:24]), dwords 8, 10, 11, 12 and the bridge control half of dword 15 [31:16] read zero. The base/limit range bits also read zero: dword 7 bits [15:12] and [7:4], and dwords 8 and 9 bits [31:20] and [15:4].
- R2: A write changes only bytes whose byte enable is set, and only the writable bits within them. Command bits [2:0] of dword 1 are writable. Dword 6 is fully writable. Dwords 7, 8 and 9 are writable in their range bits only. Dwords 10, 11 and 12 are fully writable. Dword 15 bits [23:16] are writable. Every other bit, and every dword not listed, ignores writes.
- R3: A `fwd_off` strobe sets every base range bit (dword 7 [7:4], dwords 8 and 9 [15:4]), clears every limit range bit (dword 7 [15:12], dwords 8 and 9 [31:20]) and zeroes dwords 10 and 11. It takes precedence over a write to the same bits in the same cycle and leaves all other bits unchanged.
- R4: When bit 22 of dword 15 (bus reset) changes from 0 to 1, `sec_bus_rst` is high for exactly one cycle. That cycle is the one following the first clock edge at which the stored bit reads 1.
- R5: `sec_bus_rst` stays low while bit 22 remains 1, when it falls, and when it is rewritten with 1 while already 1.
- R6: Dword 3 bits [23:16] read 0x01 (bridge layout), with bit 23 equal to `multifn_in` (multifunction flag kept).
- R7: Dword 2 reads class 0x060400 in bits [31:8] and the revision parameter in [7:0]. Dword 0 reads the identity parameters.
- R8: Bits 21 (66 MHz capable) and 23 (fast back-to-back capable) read 1 in dword 1 (primary status) and in dword 7 (secondary status), and writes cannot clear them.
- R9: When `sec_express` is 1 and `slt_compat` is 0, the latency timer (dword 6 [31:24]) reads zero and ignores writes. Otherwise it is writable.
- R10: With default parameters, dword 7 bits [3:0] and [11:8] read 0x1 (32-bit I/O), and dword 9 bits [3:0] and [19:16] read 0x1 (64-bit prefetchable). These bits are read-only and are never altered by `fwd_off`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Write strobe, one cycle per write |
| cfg_wr_idx | input | 6 | Dword index of the write |
| cfg_be | input | 4 | Byte enables of the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rd_idx | input | 6 | Dword index to read |
| cfg_rdata | output | 32 | Read data, combinational from the index |
| fwd_off | input | 1 | Strobe that closes all forwarding windows |
| multifn_in | input | 1 | Multifunction flag carried into the header type |
| sec_express | input | 1 | Secondary side is an express link |
| slt_compat | input | 1 | Keeps the latency timer writable on an express link |
| sec_bus_rst | output | 1 | One-cycle secondary bus reset pulse |

## Verification
Assertions check several rules on every cycle: stored bits stay unchanged without a write or strobe, protected bits never move, a strobe closes the windows, the reset pulse lasts one cycle and follows a fresh rising transition, and the status flags and header layout read correctly. Other behaviour depends on a reference model, and only the bench's scenarios show it. That covers the byte-enable merge across random data and lane patterns, switching the latency timer between writable and read-only as the straps change, a write and a strobe colliding in one cycle, and the absence of a pulse on repeated or falling writes to the reset bit.

// File: rtl/pcib_cfg_pkg.sv
package pcib_cfg_pkg;

  localparam int DW       = 32;
  localparam int NSLOT    = 9;
  localparam int SLOT_BUS = 1;
  localparam int SLOT_BCT = 8;
  localparam int BUSRST_BIT = 22;
  localparam logic [31:0] LAT_BYTE   = 32'hFF00_0000;
  localparam logic [31:0] STAT_FLAGS = 32'h00A0_0000;
  localparam logic [23:0] CLASS_P2P  = 24'h060400;

  // Dword index served by each storage slot.
  function automatic int slot_idx(input int s);
    case (s)
      0: return 1;
      1: return 6;
      2: return 7;
      3: return 8;
      4: return 9;
      5: return 10;
      6: return 11;
      7: return 12;
      default: return 15;
    endcase
  endfunction

  function automatic logic [31:0] slot_rst(input int s, input bit io32, input bit pref64);
    logic [3:0] it;
    logic [3:0] pt;
    it = io32 ? 4'h1 : 4'h0;
    pt = pref64 ? 4'h1 : 4'h0;
    case (s)
      0: return STAT_FLAGS;
      2: return {16'h00A0, 4'h0, it, 4'h0, it};
      4: return {12'h000, pt, 12'h000, pt};
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] slot_wmask(input int s, input bit io32, input bit pref64,
                                             input logic [15:0] cmd_wm,
                                             input logic [15:0] bct_wm);
    case (s)
      0: return {16'h0000, cmd_wm};
      1: return 32'hFFFF_FFFF;
      2: return 32'h0000_F0F0;
      3: return 32'hFFF0_FFF0;
      4: return 32'hFFF0_FFF0;
      5: return pref64 ? 32'hFFFF_FFFF : 32'h0;
      6: return pref64 ? 32'hFFFF_FFFF : 32'h0;
      7: return io32 ? 32'hFFFF_FFFF : 32'h0;
      default: return {bct_wm, 16'h0000};
    endcase
  endfunction

  // Bits driven by the window-closing strobe, and the values they take.
  function automatic logic [31:0] slot_fmask(input int s);
    case (s)
      2: return 32'h0000_F0F0;
      3: return 32'hFFF0_FFF0;
      4: return 32'hFFF0_FFF0;
      5: return 32'hFFFF_FFFF;
      6: return 32'hFFFF_FFFF;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] slot_fval(input int s);
    case (s)
      2: return 32'h0000_00F0;
      3: return 32'h0000_FFF0;
      4: return 32'h0000_FFF0;
      default: return 32'h0;
    endcase
  endfunction

endpackage

// File: rtl/pcib_mreg.sv
module pcib_mreg #(
  parameter int          W      = 32,
  parameter logic [31:0] RSTV   = '0,
  parameter logic [31:0] FMASK  = '0,
  parameter logic [31:0] FVAL   = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W/8-1:0] be,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] wmask,
  input  logic         force_off,
  output logic [W-1:0] q
);
  localparam int NB = W / 8;

  logic [W-1:0] lane_m;
  logic [W-1:0] merged;
  logic [W-1:0] nxt;

  always_comb begin
    for (int b = 0; b < NB; b++) begin
      lane_m[b*8 +: 8] = {8{be[b] & wr_en}};
    end
    merged = (q & ~(wmask & lane_m)) | (wdata & wmask & lane_m);
    nxt    = force_off ? ((merged & ~FMASK[W-1:0]) | (FVAL[W-1:0] & FMASK[W-1:0])) : merged;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q <= RSTV[W-1:0];
    else        q <= nxt;
  end

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !force_off) |=> $stable(q));

  assert_ro_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !force_off |=> (((q ^ $past(q)) & ~$past(wmask)) == '0));

  assert_close_R3: assert property (@(posedge clk) disable iff (!rst_n)
    force_off |=> ((q & FMASK[W-1:0]) == (FVAL[W-1:0] & FMASK[W-1:0])));
endmodule

// File: rtl/pcib_rise_pulse.sv
module pcib_rise_pulse (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  output logic pulse
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      pulse  <= 1'b0;
    end else begin
      prev_q <= level;
      pulse  <= level & ~prev_q;
    end
  end

  assert_one_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse);

  assert_fresh_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |-> ($past(level) && !$past(level, 2)));
endmodule

// File: rtl/pcib_cfg_regs.sv
module pcib_cfg_regs #(
  parameter int          IDX_W         = 6,
  parameter logic [15:0] VENDOR_ID     = 16'hABCD,
  parameter logic [15:0] DEVICE_ID     = 16'h0123,
  parameter logic [7:0]  REV_ID        = 8'h02,
  parameter bit          IO_32BIT      = 1'b1,
  parameter bit          PREF_64BIT    = 1'b1,
  parameter bit          RESET_CLOSED  = 1'b0,
  parameter logic [15:0] CMD_WMASK     = 16'h0007,
  parameter logic [15:0] BCTL_WMASK    = 16'h00FF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [IDX_W-1:0] cfg_wr_idx,
  input  logic [3:0]       cfg_be,
  input  logic [31:0]      cfg_wdata,
  input  logic [IDX_W-1:0] cfg_rd_idx,
  output logic [31:0]      cfg_rdata,
  input  logic             fwd_off,
  input  logic             multifn_in,
  input  logic             sec_express,
  input  logic             slt_compat,
  output logic             sec_bus_rst
);
  import pcib_cfg_pkg::*;

  logic        lat_ro;
  logic [31:0] slot_q [NSLOT];

  assign lat_ro = sec_express & ~slt_compat;

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    localparam int          IDX = slot_idx(s);
    localparam logic [31:0] FM  = slot_fmask(s);
    localparam logic [31:0] FV  = slot_fval(s);
    localparam logic [31:0] R0  = slot_rst(s, IO_32BIT, PREF_64BIT);
    localparam logic [31:0] RV  = RESET_CLOSED ? ((R0 & ~FM) | (FV & FM)) : R0;
    localparam logic [31:0] WM0 = slot_wmask(s, IO_32BIT, PREF_64BIT, CMD_WMASK, BCTL_WMASK);

    logic [31:0] wm;
    if (s == SLOT_BUS) begin : g_lat
      assign wm = lat_ro ? (WM0 & ~LAT_BYTE) : WM0;
    end else begin : g_fix
      assign wm = WM0;
    end

    pcib_mreg #(.W(DW), .RSTV(RV), .FMASK(FM), .FVAL(FV)) u_reg (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (cfg_wr && (cfg_wr_idx == IDX_W'(IDX))),
      .be       (cfg_be),
      .wdata    (cfg_wdata),
      .wmask    (wm),
      .force_off(fwd_off),
      .q        (slot_q[s])
    );
  end

  always_comb begin
    cfg_rdata = '0;
    case (cfg_rd_idx)
      IDX_W'(0): cfg_rdata = {DEVICE_ID, VENDOR_ID};
      IDX_W'(2): cfg_rdata = {CLASS_P2P, REV_ID};
      IDX_W'(3): cfg_rdata = {8'h00, multifn_in, 7'h01, 16'h0000};
      default: begin
        for (int s = 0; s < NSLOT; s++) begin
          if (cfg_rd_idx == IDX_W'(slot_idx(s))) cfg_rdata = slot_q[s];
        end
        if (cfg_rd_idx == IDX_W'(slot_idx(SLOT_BUS)) && lat_ro)
          cfg_rdata = cfg_rdata & ~LAT_BYTE;
      end
    endcase
  end

  pcib_rise_pulse u_busrst (
    .clk  (clk),
    .rst_n(rst_n),
    .level(slot_q[SLOT_BCT][BUSRST_BIT]),
    .pulse(sec_bus_rst)
  );

  assert_busrst_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(slot_q[SLOT_BCT][BUSRST_BIT]) |=> sec_bus_rst);

  assert_status_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((slot_q[0] & STAT_FLAGS) == STAT_FLAGS) && ((slot_q[2] & STAT_FLAGS) == STAT_FLAGS));

  assert_header_layout_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rd_idx == IDX_W'(3)) |-> (cfg_rdata[22:16] == 7'h01 && cfg_rdata[23] == multifn_in));
endmodule

// File: tb/pcib_cfg_regs_tb.sv
module pcib_cfg_regs_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [5:0]  cfg_wr_idx = '0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_wdata = '0;
  logic [5:0]  cfg_rd_idx = '0;
  logic [31:0] cfg_rdata;
  logic        fwd_off = 1'b0;
  logic        multifn_in = 1'b0;
  logic        sec_express = 1'b0;
  logic        slt_compat = 1'b0;
  logic        sec_bus_rst;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] mdl [16];
  bit rise_prev = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pcib_cfg_regs u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wr_idx(cfg_wr_idx),
    .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rd_idx(cfg_rd_idx),
    .cfg_rdata(cfg_rdata), .fwd_off(fwd_off), .multifn_in(multifn_in),
    .sec_express(sec_express), .slt_compat(slt_compat), .sec_bus_rst(sec_bus_rst)
  );

  function automatic logic [31:0] wm_of(int i, bit lro);
    case (i)
      1: return 32'h0000_0007;
      6: return lro ? 32'h00FF_FFFF : 32'hFFFF_FFFF;
      7: return 32'h0000_F0F0;
      8, 9: return 32'hFFF0_FFF0;
      10, 11, 12: return 32'hFFFF_FFFF;
      15: return 32'h00FF_0000;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] fm_of(int i);
    case (i)
      7: return 32'h0000_F0F0;
      8, 9: return 32'hFFF0_FFF0;
      10, 11: return 32'hFFFF_FFFF;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] fv_of(int i);
    case (i)
      7: return 32'h0000_00F0;
      8, 9: return 32'h0000_FFF0;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] exp_rd(int i);
    case (i)
      0: return 32'h0123_ABCD;
      2: return 32'h0604_0002;
      3: return {8'h00, multifn_in, 7'h01, 16'h0000};
      6: return (sec_express && !slt_compat) ? (mdl[6] & 32'h00FF_FFFF) : mdl[6];
      default: return (i < 16) ? mdl[i] : 32'h0;
    endcase
  endfunction

  function automatic string tag_of(int i);
    case (i)
      0, 2: return "R7";
      1: return "R8";
      3: return "R6";
      6: return "R9";
      7, 9: return "R10";
      8, 10, 11, 12: return "R3";
      default: return "R2";
    endcase
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 16; i++) mdl[i] = 32'h0;
    mdl[1] = 32'h00A0_0000;
    mdl[7] = 32'h00A0_0101;
    mdl[9] = 32'h0001_0001;
  endtask

  task automatic check_idx(int i, string tag);
    cfg_rd_idx = 6'(i);
    #1;
    chk(cfg_rdata === exp_rd(i), tag, cfg_rdata, exp_rd(i));
  endtask

  // One clock step: drive at negedge, update model at posedge, check at next negedge.
  task automatic step(bit wr, int idx, logic [3:0] be, logic [31:0] d, bit fo, int rd_i, string tag);
    bit old_b, rise_now;
    bit lro;
    logic [31:0] m;
    cfg_wr = wr; cfg_wr_idx = 6'(idx); cfg_be = be; cfg_wdata = d; fwd_off = fo;
    lro = sec_express && !slt_compat;
    @(posedge clk);
    old_b = mdl[15][22];
    if (wr && idx < 16) begin
      for (int b = 0; b < 4; b++) begin
        if (be[b]) begin
          m = wm_of(idx, lro) & (32'hFF << (8*b));
          mdl[idx] = (mdl[idx] & ~m) | (d & m);
        end
      end
    end
    if (fo) begin
      for (int i = 0; i < 16; i++) mdl[i] = (mdl[i] & ~fm_of(i)) | (fv_of(i) & fm_of(i));
    end
    rise_now = !old_b && mdl[15][22];
    @(negedge clk);
    cfg_wr = 1'b0; fwd_off = 1'b0;
    chk(sec_bus_rst === rise_prev, rise_prev ? "R4" : "R5", {31'h0, sec_bus_rst}, {31'h0, rise_prev});
    rise_prev = rise_now;
    check_idx(rd_i, tag);
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int i = 0; i < 18; i++) check_idx(i, (i == 6 || i == 8 || i == 15) ? "R1" : tag_of(i));
    chk(sec_bus_rst === 1'b0, "R1", {31'h0, sec_bus_rst}, 32'h0);

    // R2 write all ones everywhere, full lanes
    for (int i = 0; i < 16; i++) step(1, i, 4'hF, 32'hFFFF_FFFF, 0, i, tag_of(i));
    step(0, 0, 4'h0, 0, 0, 15, "R5");
    // R8 try to clear status flags
    step(1, 1, 4'hF, 32'h0, 0, 1, "R8");
    step(1, 7, 4'hF, 32'h0, 0, 7, "R8");
    // R2 partial byte lanes
    step(1, 6, 4'b0101, 32'h1234_5678, 0, 6, "R2");
    // R4/R5 bus reset edges
    step(1, 15, 4'h4, 32'h0, 0, 15, "R5");
    step(1, 15, 4'h4, 32'h0040_0000, 0, 15, "R4");
    step(0, 0, 4'h0, 0, 0, 15, "R4");
    step(1, 15, 4'h4, 32'h0040_0000, 0, 15, "R5");
    step(0, 0, 4'h0, 0, 0, 15, "R5");
    step(1, 15, 4'hF, 32'h0, 0, 15, "R5");
    step(0, 0, 4'h0, 0, 0, 15, "R5");
    // R3 close windows while writing the same field
    step(1, 8, 4'hF, 32'h1230_0450, 1, 8, "R3");
    for (int i = 7; i < 13; i++) check_idx(i, (i == 12) ? "R3" : "R10");
    check_idx(6, "R3");
    // R9 latency timer read-only on express
    sec_express = 1'b1;
    step(1, 6, 4'h8, 32'hAA00_0000, 0, 6, "R9");
    slt_compat = 1'b1;
    step(1, 6, 4'h8, 32'h5500_0000, 0, 6, "R9");
    // R6 multifunction flag
    multifn_in = 1'b1;
    check_idx(3, "R6");

    // random phase
    void'($urandom(32'd2024));
    for (int k = 0; k < 800; k++) begin
      int idx, rd;
      logic [3:0] be;
      bit fo;
      if (k % 100 == 0) begin
        sec_express = 1'($urandom_range(0, 1));
        slt_compat  = 1'($urandom_range(0, 1));
        multifn_in  = 1'($urandom_range(0, 1));
      end
      idx = ($urandom_range(0, 3) == 0) ? 15 : int'($urandom_range(0, 17));
      be  = 4'($urandom);
      fo  = ($urandom_range(0, 15) == 0);
      rd  = ($urandom_range(0, 1) == 0) ? idx : int'($urandom_range(0, 17));
      step($urandom_range(0, 3) != 0, idx, be, $urandom, fo, rd, tag_of(rd));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule